// File: doc/BRIEF.md
# GF(2) Block Lower-Triangular Substitution Solver

This block solves T·b = a over GF(2). T is a square grid of NBLK × NBLK blocks, each P × P. Every diagonal block is the identity, every block above the diagonal is zero, and every block below the diagonal is either all-zero or a circulant permutation given by a shift value. The right-hand side a arrives as a stream of P-bit subvectors. The solution b leaves as a stream of P-bit subvectors in row order.

No inverse matrix is formed. Row i takes its input subvector a_i as an accumulator. The solver then walks the earlier columns k < i in ascending order, one per clock, and reads the block descriptor for (i, k) from an external table port. For every nonzero block it XORs in a rotated copy of the already-solved b_k. The finished b_i is emitted and written into a local register file, because the later rows need it.

A controller starts a solve with a one-cycle start pulse while the block is idle. It feeds a_i whenever the block raises its input-ready flag and collects the b_i as they are emitted. A one-cycle done pulse closes the solve.

Top module: `ltsolve_top`

## Requirements
- R1: While reset is held and after reset is released (with no start), a_ready, b_valid, tbl_rd and done are all low.
- R2: A nonzero block with shift s maps a subvector x to y with y[r] = x[(r+s) mod P], where bit 0 is the LSB. Example for P=8, s=1: x=8'h01 gives y=8'h80. Shift values are below P.
- R3: The first solution subvector equals the first input subvector, b_0 = a_0.
- R4: For i > 0, b_i = a_i XOR the rotations of b_k by the shift of block (i,k), summed over every k < i whose table entry is nonzero. An entry with tbl_zero=1 contributes nothing, whatever tbl_shift holds.
- R5: The table is read only below the diagonal. Each cycle with tbl_rd=1 has tbl_col < tbl_row. Row i reads columns 0 to i−1 in ascending order, one per cycle.
- R6: Each solve emits exactly NBLK subvectors, one b_valid cycle each, with b_index counting 0, 1, …, NBLK−1.
- R7: While a_valid stays high, b_i is emitted exactly i+2 cycles after b_(i−1). This covers one fetch cycle, i accumulate cycles and one emit cycle.
- R8: An input subvector is taken only in a cycle where a_valid and a_ready are both high. a_ready is high only while the block waits for its next a_i. Gaps in a_valid delay the output but do not change it.
- R9: done is a one-cycle pulse in the cycle right after the last subvector (b_index = NBLK−1) is emitted, once per solve.
- R10: A start pulse while a solve is in progress is ignored. It produces no extra output, no extra done and no change to the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a solve (honoured only when idle) |
| a_valid | input | 1 | a_data holds the next right-hand subvector |
| a_data | input | P | Right-hand subvector a_i |
| a_ready | output | 1 | Block is waiting for a_i |
| tbl_rd | output | 1 | Table lookup in progress this cycle |
| tbl_row | output | $clog2(NBLK) | Block row of the lookup |
| tbl_col | output | $clog2(NBLK) | Block column of the lookup |
| tbl_shift | input | $clog2(P) | Circulant shift of block (tbl_row, tbl_col) |
| tbl_zero | input | 1 | Block (tbl_row, tbl_col) is all-zero |
| b_valid | output | 1 | b_data holds a solved subvector |
| b_index | output | $clog2(NBLK) | Row index of b_data |
| b_data | output | P | Solved subvector b_i |
| done | output | 1 | One-cycle pulse after the last subvector |

## Verification
The bench builds the solver with P=8 and NBLK=5. With 8-bit subvectors, every shift from 0 to P−1 is reachable, including the wrap-around case at P−1. Five block rows make the register file depth and the index space of $clog2(NBLK)=3 bits differ, so unused index codes exist. The last row then folds in four earlier solutions, which exercises the full triangle, a dual-diagonal pattern, and tables whose zero-flagged entries carry nonzero shift values. Input gaps and a stray start pulse are applied while a solve is in flight, so that the row-to-row latency rule and the idle-only start rule are both tested at these sizes.

// File: rtl/ltsolve_pkg.sv
package ltsolve_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_ACC   = 2'd2,
        ST_EMIT  = 2'd3
    } solve_st_e;

endpackage

// File: rtl/ltsolve_rot.sv
// Circulant block times vector: y[r] = x[(r + s) mod P], s < P.
module ltsolve_rot #(
    parameter int P  = 8,
    parameter int SW = 3
) (
    input  logic [P-1:0]  x,
    input  logic [SW-1:0] s,
    output logic [P-1:0]  y
);
    logic [2*P-1:0] twice;

    always_comb begin
        twice = {x, x};
        y     = twice[s +: P];
    end

endmodule

// File: rtl/ltsolve_buf.sv
// Register file holding the solved subvectors of the current solve.
module ltsolve_buf #(
    parameter int P    = 8,
    parameter int NBLK = 5,
    parameter int IW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [P-1:0]  wr_data,
    input  logic [IW-1:0] rd_addr,
    output logic [P-1:0]  rd_data
);
    logic [P-1:0] slot_q [NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_addr == IW'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NBLK; k++) begin
            if (rd_addr == IW'(k)) begin
                rd_data = slot_q[k];
            end
        end
    end

endmodule

// File: rtl/ltsolve_top.sv
module ltsolve_top
    import ltsolve_pkg::*;
#(
    parameter int P    = 8,
    parameter int NBLK = 5,
    localparam int SW  = (P > 1) ? $clog2(P) : 1,
    localparam int IW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          a_valid,
    input  logic [P-1:0]  a_data,
    output logic          a_ready,
    output logic          tbl_rd,
    output logic [IW-1:0] tbl_row,
    output logic [IW-1:0] tbl_col,
    input  logic [SW-1:0] tbl_shift,
    input  logic          tbl_zero,
    output logic          b_valid,
    output logic [IW-1:0] b_index,
    output logic [P-1:0]  b_data,
    output logic          done
);
    localparam logic [IW-1:0] LAST_ROW = IW'(NBLK - 1);

    typedef struct packed {
        solve_st_e     st;
        logic [IW-1:0] row;
        logic [IW-1:0] col;
        logic [P-1:0]  acc;
        logic          fin;
    } solve_s;

    solve_s       cur_q, nxt_d;
    logic         buf_we;
    logic [P-1:0] buf_rd;
    logic [P-1:0] rot_out;

    ltsolve_buf #(.P(P), .NBLK(NBLK), .IW(IW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_we),
        .wr_addr (cur_q.row),
        .wr_data (cur_q.acc),
        .rd_addr (cur_q.col),
        .rd_data (buf_rd)
    );

    ltsolve_rot #(.P(P), .SW(SW)) u_rot (
        .x (buf_rd),
        .s (tbl_shift),
        .y (rot_out)
    );

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.fin = 1'b0;
        buf_we   = 1'b0;
        a_ready  = 1'b0;
        tbl_rd   = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.st  = ST_FETCH;
                    nxt_d.row = '0;
                end
            end
            ST_FETCH: begin
                a_ready = 1'b1;
                if (a_valid) begin
                    nxt_d.acc = a_data;
                    nxt_d.col = '0;
                    nxt_d.st  = (cur_q.row == '0) ? ST_EMIT : ST_ACC;
                end
            end
            ST_ACC: begin
                tbl_rd = 1'b1;
                if (!tbl_zero) begin
                    nxt_d.acc = cur_q.acc ^ rot_out;
                end
                if (cur_q.col == cur_q.row - IW'(1)) begin
                    nxt_d.st = ST_EMIT;
                end else begin
                    nxt_d.col = cur_q.col + IW'(1);
                end
            end
            ST_EMIT: begin
                buf_we = 1'b1;
                if (cur_q.row == LAST_ROW) begin
                    nxt_d.st  = ST_IDLE;
                    nxt_d.fin = 1'b1;
                end else begin
                    nxt_d.row = cur_q.row + IW'(1);
                    nxt_d.st  = ST_FETCH;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, row: '0, col: '0, acc: '0, fin: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign tbl_row = cur_q.row;
    assign tbl_col = cur_q.col;
    assign b_valid = (cur_q.st == ST_EMIT);
    assign b_index = cur_q.row;
    assign b_data  = cur_q.acc;
    assign done    = cur_q.fin;

endmodule

// File: rtl/ltsolve_chk.sv
module ltsolve_chk #(
    parameter int P    = 8,
    parameter int NBLK = 5,
    localparam int SW  = (P > 1) ? $clog2(P) : 1,
    localparam int IW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_valid,
    input logic [P-1:0]  a_data,
    input logic          a_ready,
    input logic          tbl_rd,
    input logic [IW-1:0] tbl_row,
    input logic [IW-1:0] tbl_col,
    input logic [SW-1:0] tbl_shift,
    input logic          b_valid,
    input logic [IW-1:0] b_index,
    input logic [P-1:0]  b_data,
    input logic          done
);
    localparam logic [IW-1:0] LAST_ROW = IW'(NBLK - 1);

    logic [IW-1:0] want_idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            want_idx_q <= '0;
        end else if (b_valid) begin
            want_idx_q <= (b_index == LAST_ROW) ? '0 : b_index + IW'(1);
        end
    end

    p_below_diag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd |-> (tbl_col < tbl_row));

    p_first_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_index == '0) |-> ($past(a_valid && a_ready) && b_data == $past(a_data)));

    p_row_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> (b_index == want_idx_q));

    p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(b_valid && b_index == LAST_ROW));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ready_only_waiting_r8: assert property (@(posedge clk) disable iff (!rst_n)
        a_ready |-> (!b_valid && !tbl_rd && !done));

endmodule

bind ltsolve_top ltsolve_chk #(.P(P), .NBLK(NBLK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_valid   (a_valid),
    .a_data    (a_data),
    .a_ready   (a_ready),
    .tbl_rd    (tbl_rd),
    .tbl_row   (tbl_row),
    .tbl_col   (tbl_col),
    .tbl_shift (tbl_shift),
    .b_valid   (b_valid),
    .b_index   (b_index),
    .b_data    (b_data),
    .done      (done)
);

// File: tb/ltsolve_top_tb.sv
module ltsolve_top_tb;
    localparam int P    = 8;
    localparam int NBLK = 5;
    localparam int SW   = $clog2(P);
    localparam int IW   = $clog2(NBLK);
    localparam int DEP  = 2 ** IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          a_valid = 1'b0;
    logic [P-1:0]  a_data = '0;
    logic          a_ready, tbl_rd, tbl_zero, b_valid, done;
    logic [IW-1:0] tbl_row, tbl_col, b_index;
    logic [SW-1:0] tbl_shift;
    logic [P-1:0]  b_data;

    logic [SW-1:0] sh [DEP][DEP];
    logic          zr [DEP][DEP];
    logic [P-1:0]  av [NBLK];
    logic [P-1:0]  got [NBLK];

    int            qi [$];
    logic [P-1:0]  qd [$];
    int n_chk = 0, n_bad = 0;
    int cyc = 0, last_b_cyc = 0, done_cnt = 0;
    bit nogap = 0;
    bit prev_last = 0;

    always #5 clk = ~clk;

    assign tbl_shift = sh[tbl_row][tbl_col];
    assign tbl_zero  = zr[tbl_row][tbl_col];

    ltsolve_top #(.P(P), .NBLK(NBLK)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
        .tbl_rd(tbl_rd), .tbl_row(tbl_row), .tbl_col(tbl_col),
        .tbl_shift(tbl_shift), .tbl_zero(tbl_zero),
        .b_valid(b_valid), .b_index(b_index), .b_data(b_data), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary_exit();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [P-1:0] rot(input logic [P-1:0] x, input int s);
        logic [P-1:0] y;
        for (int r = 0; r < P; r++) y[r] = x[(r + s) % P];
        return y;
    endfunction

    // Monitor and scoreboard
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            summary_exit();
        end
        if (rst_n) begin
            if (tbl_rd)
                check(tbl_col < tbl_row, "R5 lookup below diagonal", int'(tbl_col), int'(tbl_row));
            if (done) begin
                done_cnt <= done_cnt + 1;
                check(prev_last, "R9 done follows last output", 0, 1);
            end
            prev_last <= b_valid && (int'(b_index) == NBLK - 1);
            if (b_valid) begin
                if (qi.size() == 0) begin
                    check(0, "R10 unexpected output", int'(b_index), -1);
                end else begin
                    int ei;
                    logic [P-1:0] ed;
                    ei = qi.pop_front();
                    ed = qd.pop_front();
                    check(int'(b_index) == ei, "R6 output index", int'(b_index), ei);
                    check(b_data == ed, (ei == 0) ? "R3 first subvector" : "R4 solved subvector",
                          int'(b_data), int'(ed));
                    if (nogap && ei > 0)
                        check(cyc - last_b_cyc == ei + 2, "R7 row spacing", cyc - last_b_cyc, ei + 2);
                end
                got[b_index] <= b_data;
                last_b_cyc <= cyc;
            end
        end
    end

    // Driver: mode 0 continuous input, 1 with gaps, 2 gaps plus stray start
    task automatic run_vec(input int mode);
        logic [P-1:0] bv [NBLK];
        int idx, n, d0;
        for (int i = 0; i < NBLK; i++) begin
            logic [P-1:0] acc;
            acc = av[i];
            for (int k = 0; k < i; k++)
                if (!zr[i][k]) acc ^= rot(bv[k], int'(sh[i][k]));
            bv[i] = acc;
            qi.push_back(i);
            qd.push_back(acc);
        end
        nogap = (mode == 0);
        d0 = done_cnt;
        @(negedge clk);
        start = 1'b1;
        idx = 0; n = 0;
        while (idx < NBLK) begin
            @(negedge clk);
            n++;
            start = (mode == 2 && n == 4);
            if (mode >= 1 && (n % 3) == 0) begin
                a_valid = 1'b0;
                a_data  = P'($urandom);
            end else begin
                a_valid = 1'b1;
                a_data  = av[idx];
                if (a_ready) idx++;
            end
        end
        for (int w = 0; w < 60 && done_cnt == d0; w++) begin
            @(negedge clk);
            a_valid = 1'b0;
            start   = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(done_cnt == d0 + 1, "R9 R10 one done per solve", done_cnt - d0, 1);
        check(qi.size() == 0, "R6 all outputs emitted", qi.size(), 0);
        check(!a_ready && !b_valid, "R8 idle after solve", int'(a_ready), 0);
    endtask

    task automatic tbl_clear();
        for (int r = 0; r < DEP; r++)
            for (int c = 0; c < DEP; c++) begin
                sh[r][c] = '0;
                zr[r][c] = 1'b1;
            end
    endtask

    initial begin
        tbl_clear();
        repeat (3) @(negedge clk);
        check(!a_ready && !b_valid && !tbl_rd && !done, "R1 reset outputs", int'(b_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!a_ready && !b_valid && !tbl_rd && !done, "R1 idle after reset", int'(a_ready), 0);

        // Directed rotation: T(1,0) shift 1, a0 = 01 -> b1 = 80
        zr[1][0] = 1'b0; sh[1][0] = SW'(1);
        av = '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
        run_vec(0);
        check(got[1] == 8'h80, "R2 rotation direction", int'(got[1]), 8'h80);

        // Zero-flagged blocks carrying shifts must not contribute
        tbl_clear();
        for (int r = 0; r < NBLK; r++)
            for (int c = 0; c < r; c++) sh[r][c] = SW'(r + 2 * c + 1);
        av = '{8'h3C, 8'hA5, 8'h0F, 8'h81, 8'h77};
        run_vec(0);
        check(got[4] == 8'h77 && got[2] == 8'h0F, "R4 zero blocks ignored", int'(got[4]), 8'h77);

        // Dual-diagonal pattern with shift 0 and P-1
        tbl_clear();
        for (int r = 1; r < NBLK; r++) begin
            zr[r][r-1] = 1'b0;
            sh[r][r-1] = (r % 2) ? SW'(P - 1) : SW'(0);
        end
        av = '{8'h01, 8'h10, 8'h00, 8'hFF, 8'h5A};
        run_vec(1);

        // Full triangle, random values, gaps and a stray start
        for (int v = 0; v < 6; v++) begin
            tbl_clear();
            for (int r = 0; r < NBLK; r++)
                for (int c = 0; c < r; c++) begin
                    sh[r][c] = SW'($urandom);
                    zr[r][c] = ($urandom % 4) == 0;
                end
            for (int i = 0; i < NBLK; i++) av[i] = P'($urandom);
            run_vec(v % 3);
        end

        summary_exit();
    end

endmodule